// File: doc/BRIEF.md
# Rectifier Transient Current Controller

This block is the fixed-point control datapath of a single-phase active rectifier. Each time a sample strobe arrives it captures the measured dc-link voltage and current, the grid voltage amplitude, the instantaneous grid voltage and current, and the sine and cosine of the grid phase. From these it produces a signed terminal-voltage command for the pulse-width modulator.

The current amplitude reference has two parts. The first is a PI term on the dc-link voltage error, with a clamped integrator that stops integrating while the PI sum is saturated. The second is a load-current feed-forward term: dc-link power divided by the grid amplitude. The command is the instantaneous grid voltage minus two terms. One is the inductor drop: the reactance times the reference times cosine. The other is a proportional current-tracking term: a gain times the difference between the reference times sine and the measured current. The command is saturated to the present dc-link voltage.

All sample-rate work finishes within a fixed schedule. A one-cycle valid pulse marks each new command. The phase-locked loop, the converters and the modulator sit outside this block.

Top module: `rtc_current_ctl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `cmd_o` and `cmd_vld_o` become 0 and the voltage integrator is cleared to 0.
- R2: `cmd_vld_o` is high for exactly one cycle, rising LAT = 2*DW+3 clock edges after the edge that accepted a strobe (35 with defaults). `cmd_o` changes only in that cycle.
- R3: A strobe is accepted only when no sample is in flight. A strobe seen at any of the LAT edges that follow an accepted strobe is ignored: no extra pulse appears and the integrator does not move.
- R4: Let e = vdc_ref - vdc. The proportional part is (KP*e)>>>GSH and the increment is (KI*e)>>>GSH, both floor shifts with gains in units of 2^-GSH. A positive error raises the reference.
- R5: After each update the integrator lies within ±INT_LIM.
- R6: Anti-windup works as follows. Take the proportional part plus the old integrator. If that sum is above +IREF_LIM and the increment is positive, the integrator holds. If it is below -IREF_LIM and the increment is negative, it also holds. Otherwise the integrator becomes the clamped sum of old value and increment.
- R7: The PI output is the proportional part plus the new integrator, clamped to ±IREF_LIM. The feed-forward term is also clamped to ±IREF_LIM, and so is the total reference (PI plus feed-forward).
- R8: The feed-forward term is (vdc*idc)/vamp with the quotient truncated toward zero, so its sign follows the dc-link current.
- R9: When vamp < VAMP_MIN (signed compare), the feed-forward term is 0.
- R10: Sine and cosine are signed with FRAC fraction bits (16384 = 1.0 with defaults). With ref = iref, the block computes rs = (ref*sin)>>>FRAC and rc = (ref*cos)>>>FRAC. The command is vgrid - ((XL*rc)>>>GSH) - ((GP*(rs - igrid))>>>GSH).
- R11: The command is clamped to ±L, where L is the captured vdc or 0 if that value is negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_stb_i | input | 1 | Sample strobe, captures all inputs |
| vdc_ref_i | input | DW | dc-link voltage setpoint, signed |
| vdc_i | input | DW | Measured dc-link voltage, signed |
| idc_i | input | DW | Measured dc-link current, signed |
| vamp_i | input | DW | Grid voltage amplitude, signed |
| vgrid_i | input | DW | Instantaneous grid voltage, signed |
| igrid_i | input | DW | Instantaneous grid current, signed |
| sin_i | input | DW | Sine of grid phase, FRAC fraction bits |
| cos_i | input | DW | Cosine of grid phase, FRAC fraction bits |
| cmd_o | output | DW | Terminal-voltage command, signed |
| cmd_vld_o | output | 1 | One-cycle pulse marking a new command |

## Verification
Windup is driven from two sides. A long run of moderate error reaches the integrator clamp, which an unclamped design overshoots. A large error pushes the PI sum past its limit and is then reversed; a design without conditional integration would carry stored excess and settle on a visibly different command. Further sample vectors hit the feed-forward guard on both sides of the amplitude threshold, a negative dc-link current, a quotient beyond the reference limit, and commands beyond ±vdc. A strobe injected mid-flight checks that a design accepting it would emit a second pulse or double-step the integrator.

// File: rtl/rtc_pkg.sv
// Shared arithmetic type and saturation helper for the rectifier current
// controller. All internal products are formed at a single wide signed
// width so that no intermediate result can wrap for DW up to 16.
package rtc_pkg;

    typedef logic signed [63:0] cw_t;

    // Clamp a wide value into [lo, hi]; assumes lo <= hi.
    function automatic cw_t cw_clamp(cw_t x, cw_t lo, cw_t hi);
        if (x > hi)
            return hi;
        else if (x < lo)
            return lo;
        else
            return x;
    endfunction

endpackage

// File: rtl/rtc_pi_loop.sv
// Outer dc-link voltage PI loop with a clamped integrator and conditional
// integration. On each enable it updates the integrator and registers the
// saturated PI output. Gains are integers scaled by 2^-GSH.
// Assumes INT_LIM and OUT_LIM are positive and fit in DW signed bits.
module rtc_pi_loop
    import rtc_pkg::*;
#(
    parameter int DW      = 16,
    parameter int KP      = 512,
    parameter int KI      = 64,
    parameter int GSH     = 8,
    parameter int INT_LIM = 2000,
    parameter int OUT_LIM = 4000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [DW-1:0] vref,
    input  logic signed [DW-1:0] vmeas,
    output logic signed [DW-1:0] pi_out,
    output logic signed [DW-1:0] acc_o
);

    localparam cw_t ILIM = cw_t'(INT_LIM);
    localparam cw_t OLIM = cw_t'(OUT_LIM);

    logic signed [DW-1:0] acc;
    cw_t err, p_part, inc, sum_old, acc_nx, pi_nx;
    logic hold;

    function automatic logic signed [DW-1:0] to_dw(cw_t x);
        return x[DW-1:0];
    endfunction

    // Error, proportional part, increment and anti-windup decision (R4, R6)
    always_comb begin
        err     = cw_t'(vref) - cw_t'(vmeas);
        p_part  = (cw_t'(KP) * err) >>> GSH;
        inc     = (cw_t'(KI) * err) >>> GSH;
        sum_old = p_part + cw_t'(acc);
        hold    = ((sum_old > OLIM) && (inc > 0)) ||
                  ((sum_old < -OLIM) && (inc < 0));
        acc_nx  = hold ? cw_t'(acc) : cw_clamp(cw_t'(acc) + inc, -ILIM, ILIM);
        pi_nx   = cw_clamp(p_part + acc_nx, -OLIM, OLIM);
    end

    // Integrator and PI output registers (R1, R5, R7)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            pi_out <= '0;
        end else if (en) begin
            acc    <= to_dw(acc_nx);
            pi_out <= to_dw(pi_nx);
        end
    end

    assign acc_o = acc;

endmodule

// File: rtl/rtc_ff_div.sv
// Serial restoring divider for the feed-forward term. A start pulse loads
// a signed 2*DW dividend and a positive DW divisor; one quotient bit is
// resolved per cycle for 2*DW cycles. The quotient is truncated toward
// zero. Assumes the divisor is positive when the result is used.
module rtc_ff_div #(
    parameter int DW = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic signed [2*DW-1:0] dividend,
    input  logic signed [DW-1:0]   divisor,
    output logic                   busy,
    output logic signed [2*DW:0]   quot
);

    localparam int NB = 2 * DW;
    localparam int CW = $clog2(NB + 1);

    logic [NB-1:0] wq;
    logic [NB-1:0] mag;
    logic [DW-1:0] rem;
    logic [DW-1:0] dvs;
    logic [CW-1:0] cnt;
    logic          neg;
    logic [DW:0]   rem_sh, dvs_x, rem_nx;
    logic          ge;

    // Dividend magnitude and one restoring step
    always_comb begin
        mag    = dividend[NB-1] ? NB'(-dividend) : NB'(dividend);
        rem_sh = {rem, wq[NB-1]};
        dvs_x  = {1'b0, dvs};
        ge     = rem_sh >= dvs_x;
        rem_nx = ge ? (rem_sh - dvs_x) : rem_sh;
    end

    // Load on start, then shift one quotient bit in per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wq  <= '0;
            rem <= '0;
            dvs <= '0;
            neg <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            wq  <= mag;
            rem <= '0;
            dvs <= divisor;
            neg <= dividend[NB-1];
            cnt <= CW'(NB);
        end else if (cnt != '0) begin
            wq  <= {wq[NB-2:0], ge};
            rem <= rem_nx[DW-1:0];
            cnt <= cnt - CW'(1);
        end
    end

    assign busy = (cnt != '0);
    assign quot = neg ? -$signed({1'b0, wq}) : $signed({1'b0, wq});

endmodule

// File: rtl/rtc_track_loop.sv
// Inner current-tracking stage. From the amplitude reference and the grid
// phase it forms the inductor drop and the proportional tracking term,
// subtracts both from the grid voltage and saturates the result to the
// dc-link voltage. Registered on enable. Sine and cosine carry FRAC
// fraction bits; gains carry GSH fraction bits.
module rtc_track_loop
    import rtc_pkg::*;
#(
    parameter int DW   = 16,
    parameter int GP   = 256,
    parameter int XL   = 32,
    parameter int GSH  = 8,
    parameter int FRAC = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [DW-1:0] iref,
    input  logic signed [DW-1:0] sn,
    input  logic signed [DW-1:0] cs,
    input  logic signed [DW-1:0] vin,
    input  logic signed [DW-1:0] iin,
    input  logic signed [DW-1:0] vdc,
    output logic signed [DW-1:0] cmd
);

    cw_t r_sin, r_cos, drop, dterm, raw, lim, cmd_nx;

    function automatic logic signed [DW-1:0] to_dw(cw_t x);
        return x[DW-1:0];
    endfunction

    // Instantaneous reference, drop and tracking terms, saturation (R10, R11)
    always_comb begin
        r_sin  = (cw_t'(iref) * cw_t'(sn)) >>> FRAC;
        r_cos  = (cw_t'(iref) * cw_t'(cs)) >>> FRAC;
        drop   = (cw_t'(XL) * r_cos) >>> GSH;
        dterm  = (cw_t'(GP) * (r_sin - cw_t'(iin))) >>> GSH;
        raw    = cw_t'(vin) - drop - dterm;
        lim    = vdc[DW-1] ? '0 : cw_t'(vdc);
        cmd_nx = cw_clamp(raw, -lim, lim);
    end

    // Command register (R1)
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd <= '0;
        else if (en)
            cmd <= to_dw(cmd_nx);
    end

endmodule

// File: rtl/rtc_current_ctl.sv
// Rectifier transient current controller, top level. A strobe captures all
// measurements; a fixed schedule then runs the PI update and divider
// start, waits for the serial division, forms the total amplitude
// reference and registers the saturated command with a one-cycle valid.
// Strobes during a sample in flight are ignored. Assumes IREF_LIM and
// INT_LIM fit in DW signed bits and VAMP_MIN is positive.
module rtc_current_ctl
    import rtc_pkg::*;
#(
    parameter int DW       = 16,
    parameter int KP       = 512,
    parameter int KI       = 64,
    parameter int GP       = 256,
    parameter int XL       = 32,
    parameter int GSH      = 8,
    parameter int FRAC     = 14,
    parameter int INT_LIM  = 2000,
    parameter int IREF_LIM = 4000,
    parameter int VAMP_MIN = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_stb_i,
    input  logic signed [DW-1:0] vdc_ref_i,
    input  logic signed [DW-1:0] vdc_i,
    input  logic signed [DW-1:0] idc_i,
    input  logic signed [DW-1:0] vamp_i,
    input  logic signed [DW-1:0] vgrid_i,
    input  logic signed [DW-1:0] igrid_i,
    input  logic signed [DW-1:0] sin_i,
    input  logic signed [DW-1:0] cos_i,
    output logic signed [DW-1:0] cmd_o,
    output logic                 cmd_vld_o
);

    localparam int NB  = 2 * DW;
    localparam int LAT = NB + 3;
    localparam int PHW = $clog2(LAT + 1);
    localparam logic [PHW-1:0] PH_RUN  = PHW'(1);
    localparam logic [PHW-1:0] PH_IREF = PHW'(LAT - 1);
    localparam logic [PHW-1:0] PH_OUT  = PHW'(LAT);
    localparam logic signed [DW-1:0] VMIN_L = VAMP_MIN[DW-1:0];
    localparam cw_t RLIM = cw_t'(IREF_LIM);

    logic [PHW-1:0] ph;
    logic           accept, pi_en, iref_en, out_en;
    logic signed [DW-1:0] cap_vref, cap_vdc, cap_idc, cap_vamp;
    logic signed [DW-1:0] cap_vin, cap_iin, cap_sin, cap_cos;
    logic                 cap_ffz;
    logic signed [NB-1:0] power;
    logic signed [NB:0]   quot;
    logic                 div_busy;
    logic signed [DW-1:0] pi_out, pi_acc, iref;
    cw_t ff_term, iref_nx;

    function automatic logic signed [DW-1:0] to_dw(cw_t x);
        return x[DW-1:0];
    endfunction

    // Schedule decode
    always_comb begin
        accept  = smp_stb_i && (ph == '0);
        pi_en   = (ph == PH_RUN);
        iref_en = (ph == PH_IREF);
        out_en  = (ph == PH_OUT);
    end

    // Phase counter: idle at zero, runs 1..LAT after an accepted strobe (R2, R3)
    always_ff @(posedge clk) begin
        if (!rst_n)
            ph <= '0;
        else if (ph == '0)
            ph <= accept ? PH_RUN : '0;
        else if (out_en)
            ph <= '0;
        else
            ph <= ph + PHW'(1);
    end

    // Capture all measurements and the divider guard on an accepted strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vref <= '0;
            cap_vdc  <= '0;
            cap_idc  <= '0;
            cap_vamp <= '0;
            cap_vin  <= '0;
            cap_iin  <= '0;
            cap_sin  <= '0;
            cap_cos  <= '0;
            cap_ffz  <= 1'b1;
        end else if (accept) begin
            cap_vref <= vdc_ref_i;
            cap_vdc  <= vdc_i;
            cap_idc  <= idc_i;
            cap_vamp <= vamp_i;
            cap_vin  <= vgrid_i;
            cap_iin  <= igrid_i;
            cap_sin  <= sin_i;
            cap_cos  <= cos_i;
            cap_ffz  <= (vamp_i < VMIN_L);
        end
    end

    // dc-link power as the feed-forward dividend
    assign power = {{DW{cap_vdc[DW-1]}}, cap_vdc} * {{DW{cap_idc[DW-1]}}, cap_idc};

    rtc_pi_loop #(
        .DW(DW), .KP(KP), .KI(KI), .GSH(GSH),
        .INT_LIM(INT_LIM), .OUT_LIM(IREF_LIM)
    ) pi_i (
        .clk(clk), .rst_n(rst_n), .en(pi_en),
        .vref(cap_vref), .vmeas(cap_vdc),
        .pi_out(pi_out), .acc_o(pi_acc)
    );

    rtc_ff_div #(.DW(DW)) div_i (
        .clk(clk), .rst_n(rst_n), .start(pi_en),
        .dividend(power), .divisor(cap_vamp),
        .busy(div_busy), .quot(quot)
    );

    // Guarded, clamped feed-forward and total reference (R7, R8, R9)
    always_comb begin
        ff_term = cap_ffz ? '0 : cw_clamp(cw_t'(quot), -RLIM, RLIM);
        iref_nx = cw_clamp(cw_t'(pi_out) + ff_term, -RLIM, RLIM);
    end

    // Amplitude reference register
    always_ff @(posedge clk) begin
        if (!rst_n)
            iref <= '0;
        else if (iref_en)
            iref <= to_dw(iref_nx);
    end

    rtc_track_loop #(
        .DW(DW), .GP(GP), .XL(XL), .GSH(GSH), .FRAC(FRAC)
    ) trk_i (
        .clk(clk), .rst_n(rst_n), .en(out_en),
        .iref(iref), .sn(cap_sin), .cs(cap_cos),
        .vin(cap_vin), .iin(cap_iin), .vdc(cap_vdc),
        .cmd(cmd_o)
    );

    // Valid pulse in the cycle the new command appears (R2)
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_vld_o <= 1'b0;
        else
            cmd_vld_o <= out_en;
    end

endmodule

// File: rtl/rtc_ctl_chk.sv
// Property checker for the rectifier current controller, bound into the
// top module. Observes the schedule, integrator, divider and outputs.
module rtc_ctl_chk #(
    parameter int DW      = 16,
    parameter int INT_LIM = 2000,
    parameter int LAT     = 35
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  stb,
    input logic [$clog2(LAT+1)-1:0] ph,
    input logic signed [DW-1:0]  cmd,
    input logic                  vld,
    input logic signed [DW-1:0]  vdc_cap,
    input logic signed [DW-1:0]  acc,
    input logic                  iref_en,
    input logic                  div_busy
);

    localparam int PHW = $clog2(LAT + 1);
    localparam logic [PHW-1:0] PH_ONE = PHW'(1);
    localparam logic [PHW-1:0] PH_END = PHW'(LAT);
    localparam logic signed [DW-1:0] ILIM = INT_LIM[DW-1:0];

    logic signed [DW:0] cmd_x, lim_x;
    assign cmd_x = {cmd[DW-1], cmd};
    assign lim_x = vdc_cap[DW-1] ? '0 : {1'b0, vdc_cap};

    AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> !vld); // R2
    AST_VLD_ON_SCHEDULE: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> ($past(ph) == PH_END)); // R2
    AST_CMD_ONLY_WITH_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd) |-> vld); // R2
    AST_BUSY_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ph != '0 && stb) |=> (ph != PH_ONE)); // R3
    AST_ACC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc <= ILIM) && (acc >= -ILIM)); // R5
    AST_DIV_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        iref_en |-> !div_busy); // R8
    AST_CMD_WITHIN_VDC: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> ((cmd_x <= lim_x) && (cmd_x >= -lim_x))); // R11

endmodule

bind rtc_current_ctl rtc_ctl_chk #(
    .DW(DW), .INT_LIM(INT_LIM), .LAT(LAT)
) chk_i (
    .clk(clk), .rst_n(rst_n), .stb(smp_stb_i), .ph(ph),
    .cmd(cmd_o), .vld(cmd_vld_o), .vdc_cap(cap_vdc),
    .acc(pi_acc), .iref_en(iref_en), .div_busy(div_busy)
);

// File: tb/rtc_current_ctl_tb.sv
// Self-checking bench: a table of stimulus vectors walked by one loop with
// expected commands from an independent model, then directed tests.
module rtc_current_ctl_tb_top;

    localparam int DW = 16, KP = 512, KI = 64, GP = 256, XL = 32;
    localparam int GSH = 8, FRAC = 14, INT_LIM = 2000, IREF_LIM = 4000;
    localparam int VAMP_MIN = 64;
    localparam int LAT = 2 * DW + 3;

    typedef struct packed {
        logic signed [15:0] vref, vdc, idc, vamp, vin, iin, sn, cs;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{16'sd400,  16'sd400,  16'sd100,   16'sd300,  16'sd250,   16'sd50,  16'sd16384,  16'sd0},
        '{16'sd420,  16'sd400,  16'sd50,    16'sd320, -16'sd200,  -16'sd30, -16'sd11585,  16'sd11585},
        '{16'sd380,  16'sd400, -16'sd80,    16'sd300,  16'sd100,   16'sd10,  16'sd8192,  -16'sd14189},
        '{16'sd400,  16'sd100,  16'sd0,     16'sd300,  16'sd3000,  16'sd0,   16'sd0,      16'sd0},
        '{16'sd100,  16'sd100,  16'sd0,     16'sd300, -16'sd3000,  16'sd0,   16'sd0,      16'sd0},
        '{16'sd400,  16'sd400,  16'sd1000,  16'sd20,   16'sd50,    16'sd0,   16'sd16384,  16'sd0},
        '{16'sd400,  16'sd400,  16'sd1000,  16'sd63,   16'sd50,    16'sd0,   16'sd16384,  16'sd0},
        '{16'sd400,  16'sd400,  16'sd96,    16'sd64,   16'sd50,    16'sd0,   16'sd16384,  16'sd0},
        '{16'sd1000, 16'sd1000, 16'sd1000,  16'sd100,  16'sd0,     16'sd0,   16'sd16384,  16'sd0},
        '{16'sd400, -16'sd50,   16'sd0,     16'sd300,  16'sd500,   16'sd0,   16'sd0,      16'sd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_stb = 1'b0;
    logic signed [DW-1:0] vdc_ref, vdc, idc, vamp, vgrid, igrid, sn, cs;
    logic signed [DW-1:0] cmd;
    logic cmd_vld;

    int n_chk = 0;
    int n_bad = 0;
    longint m_acc = 0;

    always #5 clk = ~clk;

    rtc_current_ctl #(
        .DW(DW), .KP(KP), .KI(KI), .GP(GP), .XL(XL), .GSH(GSH), .FRAC(FRAC),
        .INT_LIM(INT_LIM), .IREF_LIM(IREF_LIM), .VAMP_MIN(VAMP_MIN)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_stb_i(smp_stb),
        .vdc_ref_i(vdc_ref), .vdc_i(vdc), .idc_i(idc), .vamp_i(vamp),
        .vgrid_i(vgrid), .igrid_i(igrid), .sin_i(sn), .cos_i(cs),
        .cmd_o(cmd), .cmd_vld_o(cmd_vld)
    );

    function automatic longint clampl(longint x, longint lo, longint hi);
        return (x > hi) ? hi : ((x < lo) ? lo : x);
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Requirement model: updates the integrator, returns the command
    task automatic model(input vec_t v, output longint exp);
        longint e, p, inc, s, pi, ff, ir, rs, rc, dr, dt, raw, lim;
        e   = longint'(v.vref) - longint'(v.vdc);
        p   = (KP * e) >>> GSH;
        inc = (KI * e) >>> GSH;
        s   = p + m_acc;
        if (!((s > IREF_LIM && inc > 0) || (s < -IREF_LIM && inc < 0)))
            m_acc = clampl(m_acc + inc, -INT_LIM, INT_LIM);
        pi  = clampl(p + m_acc, -IREF_LIM, IREF_LIM);
        if (longint'(v.vamp) < VAMP_MIN) ff = 0;
        else ff = clampl((longint'(v.vdc) * longint'(v.idc)) / longint'(v.vamp), -IREF_LIM, IREF_LIM);
        ir  = clampl(pi + ff, -IREF_LIM, IREF_LIM);
        rs  = (ir * longint'(v.sn)) >>> FRAC;
        rc  = (ir * longint'(v.cs)) >>> FRAC;
        dr  = (XL * rc) >>> GSH;
        dt  = (GP * (rs - longint'(v.iin))) >>> GSH;
        raw = longint'(v.vin) - dr - dt;
        lim = (v.vdc < 0) ? 0 : longint'(v.vdc);
        exp = clampl(raw, -lim, lim);
    endtask

    task automatic drive(input vec_t v);
        vdc_ref = v.vref; vdc = v.vdc; idc = v.idc; vamp = v.vamp;
        vgrid = v.vin; igrid = v.iin; sn = v.sn; cs = v.cs;
    endtask

    // One sample: latency, command and pulse width
    task automatic apply(input vec_t v, input string tag);
        longint exp;
        int lat;
        @(negedge clk);
        drive(v);
        smp_stb = 1'b1;
        model(v, exp);
        @(posedge clk); #1 smp_stb = 1'b0;
        lat = 0;
        while (!cmd_vld && lat < LAT + 8) begin
            @(posedge clk); #1;
            lat++;
        end
        check(lat == LAT, "R2 latency", lat, LAT);
        check(longint'(cmd) == exp, tag, longint'(cmd), exp);
        @(posedge clk); #1;
        check(cmd_vld == 1'b0, "R2 pulse width", longint'(cmd_vld), 0);
    endtask

    function automatic vec_t mk(longint err);
        vec_t v;
        v = '{vref: 16'(5000 + err), vdc: 16'sd5000, idc: 16'sd0, vamp: 16'sd300,
              vin: 16'sd0, iin: 16'sd0, sn: 16'sd16384, cs: 16'sd0};
        return v;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        m_acc = 0;
        check(cmd == '0, "R1 reset cmd", longint'(cmd), 0);
        check(cmd_vld == 1'b0, "R1 reset valid", longint'(cmd_vld), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        drive(VECS[0]);
        repeat (4) @(negedge clk);
        do_reset();

        // Table walk (R4 R7 R8 R9 R10 R11)
        for (int i = 0; i < NV; i++)
            apply(VECS[i], "R4/R7/R8/R9/R10/R11 vector command");

        // Anti-windup: saturate, then reverse the error (R6)
        do_reset();
        apply(mk(0), "R1 integrator cleared after reset");
        for (int k = 0; k < 6; k++)
            apply(mk(1600), "R6 saturated PI holds integrator");
        apply(mk(-400), "R6 recovery after saturation");

        // Integrator clamp (R5)
        do_reset();
        for (int k = 0; k < 13; k++)
            apply(mk(800), "R5 integrator clamp");
        apply(mk(-8), "R5 clamped integrator value");

        // Strobe while busy is ignored (R3)
        begin
            vec_t a, b;
            longint exp;
            int first, pulses;
            a = mk(200);
            b = mk(-1600);
            b.vin = 16'sd1234;
            @(negedge clk);
            drive(a);
            smp_stb = 1'b1;
            model(a, exp);
            @(posedge clk); #1 smp_stb = 1'b0;
            first = 0;
            pulses = 0;
            for (int i = 1; i <= LAT + 10; i++) begin
                @(posedge clk); #1;
                if (cmd_vld) begin
                    pulses++;
                    if (first == 0) begin
                        first = i;
                        check(longint'(cmd) == exp, "R3 command from first strobe", longint'(cmd), exp);
                    end
                end
                if (i == 5) begin
                    drive(b);
                    smp_stb = 1'b1;
                end
                if (i == 6) smp_stb = 1'b0;
            end
            check(first == LAT, "R3 first pulse timing", first, LAT);
            check(pulses == 1, "R3 single pulse", pulses, 1);
        end
        apply(mk(0), "R3 integrator stepped once");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule